// File: doc/BRIEF.md
# Programmable Sample Timer with Timed Sleep

This block produces the internal sample strobe of a sensor front end. A free-running divider turns the system clock into an 8192 Hz tick enable. An 8-bit rate setting sets the interval between strobes. Its top bit picks a coarse or a fine time base, and its low seven bits give a multiplier. At the 8192 Hz tick the fine base is 2 ticks (244.14 µs) and the coarse base is 62 ticks (7.568 ms). Every interval also carries a fixed offset of 1 tick (122.07 µs), so an interval is 2·M+1 or 62·M+1 ticks. After reset the setting is 0x01, which gives 3 ticks: 366.21 µs, or about 2731 samples per second.

The block derives a rate-class flag from the programmed setting. Settings up to 0x07 count as fast and larger settings as normal. Software can also write a sleep count, in units of half a second (4096 ticks). While a sleep runs, no strobes are produced. A running sleep cannot be cut short or extended by further writes, and only reset ends it early. When a sleep runs out, sampling restarts with a fresh interval.

Top module: `sample_sleep_timer`

## Requirements
- R1: With tick period T = CLK_DIV clock cycles, the interval between consecutive strobes is (B·M+1)·T cycles, where M is setting bits 6:0 and B is 2 when setting bit 7 is 0 and 62 when it is 1.
- R2: After reset the setting is 0x01 (interval of 3 ticks), and sample_stb and sleep_act are low while fast_mode is high.
- R3: When CLK_DIV is 2 or more, sample_stb is high for exactly one clock per sample.
- R4: In the cycle after a write of value V to the rate setting, fast_mode is 1 when V ≤ 0x07 and 0 otherwise.
- R5: A new rate setting takes effect at the next strobe. The interval in progress when the write happens ends with the old length.
- R6: A multiplier of 0 gives an interval of one tick, with either time base.
- R7: A write of a nonzero sleep count N while awake raises sleep_act in the next cycle. sleep_act then stays high for N·H ticks, with H = HALF_SEC_TICKS (4096 by default, i.e. 0.5 s).
- R8: No strobe is produced while asleep. After wake-up, the first strobe arrives one full interval (counted from zero) later.
- R9: A sleep write of zero has no effect, and a sleep write during an active sleep neither extends nor shortens it.
- R10: Once started, a sleep ends early only through reset, which also restores the default setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| period_wr | input | 1 | One-cycle write strobe for the rate setting |
| period_val | input | 8 | Rate setting: bit 7 time-base select, bits 6:0 multiplier |
| sleep_wr | input | 1 | One-cycle write strobe for the sleep count |
| sleep_val | input | 8 | Sleep count in half-second units |
| sample_stb | output | 1 | One-cycle sample strobe |
| fast_mode | output | 1 | High when the programmed setting is 0x07 or below |
| sleep_act | output | 1 | High while a timed sleep runs |

## Verification
The checker relies on two assumptions about the inputs. First, nothing is written while reset or the two-flop reset release is still in progress. Second, write strobes are single-cycle pulses sampled on the rising edge. The stimulus meets both: it waits several cycles after reset release, and it raises and lowers every write on falling edges. The strobe-width property is enabled only for dividers of 2 or more, because with a divider of 1 and a one-tick interval the strobe stays high on purpose. The bench runs with a divider of 2 and a half-second unit of 8 ticks, so that sleeps finish quickly.

// File: rtl/sst_pkg.sv
package sst_pkg;

  // Length of one sample interval in ticks for a given base select and multiplier.
  function automatic int unsigned interval_ticks(
    input logic        coarse_sel,
    input int unsigned mult,
    input int unsigned fine_base,
    input int unsigned coarse_base,
    input int unsigned offset
  );
    return (coarse_sel ? coarse_base : fine_base) * mult + offset;
  endfunction

endpackage

// File: rtl/sst_tick_gen.sv
module sst_tick_gen #(
  parameter int unsigned CLK_DIV = 15259
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;
  logic             wrap;

  always_comb begin
    wrap   = (cnt_q == DIV_W'(CLK_DIV - 1));
    cnt_d  = wrap ? '0 : cnt_q + DIV_W'(1);
    tick_d = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/sst_period_timer.sv
module sst_period_timer
  import sst_pkg::*;
#(
  parameter int unsigned SET_W       = 8,
  parameter int unsigned FINE_BASE   = 2,
  parameter int unsigned COARSE_BASE = 62,
  parameter int unsigned OFFSET      = 1,
  parameter int unsigned FAST_LIMIT  = 7,
  parameter int unsigned RESET_SET   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             hold,
  input  logic             wr,
  input  logic [SET_W-1:0] val,
  output logic             stb,
  output logic             fast
);
  localparam int unsigned MULT_W  = SET_W - 1;
  localparam int unsigned MAX_LEN = COARSE_BASE * ((2 ** MULT_W) - 1) + OFFSET;
  localparam int unsigned PER_W   = $clog2(MAX_LEN + 1);

  logic [SET_W-1:0] set_q, set_d;
  logic [SET_W-1:0] act_q, act_d;
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             stb_q, stb_d;
  logic [PER_W-1:0] len;
  logic             last;

  always_comb begin
    len   = PER_W'(interval_ticks(act_q[SET_W-1], 32'(act_q[MULT_W-1:0]),
                                  FINE_BASE, COARSE_BASE, OFFSET));
    last  = (cnt_q == len - PER_W'(1));
    set_d = wr ? val : set_q;
    act_d = act_q;
    cnt_d = cnt_q;
    stb_d = 1'b0;
    if (hold) begin
      cnt_d = '0;
      act_d = set_q;
    end else if (tick) begin
      if (last) begin
        cnt_d = '0;
        stb_d = 1'b1;
        act_d = set_q;
      end else begin
        cnt_d = cnt_q + PER_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q <= SET_W'(RESET_SET);
      act_q <= SET_W'(RESET_SET);
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      set_q <= set_d;
      act_q <= act_d;
      cnt_q <= cnt_d;
      stb_q <= stb_d;
    end
  end

  assign stb  = stb_q;
  assign fast = (set_q <= SET_W'(FAST_LIMIT));
endmodule

// File: rtl/sst_sleep_ctl.sv
module sst_sleep_ctl #(
  parameter int unsigned SLEEP_W        = 8,
  parameter int unsigned HALF_SEC_TICKS = 4096
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               wr,
  input  logic [SLEEP_W-1:0] val,
  output logic               active
);
  localparam int unsigned MAX_TICKS = ((2 ** SLEEP_W) - 1) * HALF_SEC_TICKS;
  localparam int unsigned SCNT_W    = $clog2(MAX_TICKS + 1);

  logic              act_q, act_d;
  logic [SCNT_W-1:0] scnt_q, scnt_d;
  logic              start;

  always_comb begin
    start  = wr && !act_q && (val != '0);
    act_d  = act_q;
    scnt_d = scnt_q;
    if (start) begin
      act_d  = 1'b1;
      scnt_d = SCNT_W'(val) * SCNT_W'(HALF_SEC_TICKS);
    end else if (act_q && tick) begin
      if (scnt_q == SCNT_W'(1)) begin
        act_d  = 1'b0;
        scnt_d = '0;
      end else begin
        scnt_d = scnt_q - SCNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      scnt_q <= '0;
    end else begin
      act_q  <= act_d;
      scnt_q <= scnt_d;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/sample_sleep_timer.sv
module sample_sleep_timer #(
  parameter int unsigned CLK_DIV        = 15259,
  parameter int unsigned SET_W          = 8,
  parameter int unsigned SLEEP_W        = 8,
  parameter int unsigned FINE_BASE      = 2,
  parameter int unsigned COARSE_BASE    = 62,
  parameter int unsigned OFFSET         = 1,
  parameter int unsigned FAST_LIMIT     = 7,
  parameter int unsigned RESET_SET      = 1,
  parameter int unsigned HALF_SEC_TICKS = 4096
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               period_wr,
  input  logic [SET_W-1:0]   period_val,
  input  logic               sleep_wr,
  input  logic [SLEEP_W-1:0] sleep_val,
  output logic               sample_stb,
  output logic               fast_mode,
  output logic               sleep_act
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       tick;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sst_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick  (tick)
  );

  sst_sleep_ctl #(
    .SLEEP_W        (SLEEP_W),
    .HALF_SEC_TICKS (HALF_SEC_TICKS)
  ) u_sleep (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick   (tick),
    .wr     (sleep_wr),
    .val    (sleep_val),
    .active (sleep_act)
  );

  sst_period_timer #(
    .SET_W       (SET_W),
    .FINE_BASE   (FINE_BASE),
    .COARSE_BASE (COARSE_BASE),
    .OFFSET      (OFFSET),
    .FAST_LIMIT  (FAST_LIMIT),
    .RESET_SET   (RESET_SET)
  ) u_period (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick  (tick),
    .hold  (sleep_act),
    .wr    (period_wr),
    .val   (period_val),
    .stb   (sample_stb),
    .fast  (fast_mode)
  );
endmodule

// File: rtl/sample_sleep_timer_chk.sv
module sample_sleep_timer_chk #(
  parameter int unsigned CLK_DIV    = 15259,
  parameter int unsigned SET_W      = 8,
  parameter int unsigned SLEEP_W    = 8,
  parameter int unsigned FAST_LIMIT = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               period_wr,
  input logic [SET_W-1:0]   period_val,
  input logic               sleep_wr,
  input logic [SLEEP_W-1:0] sleep_val,
  input logic               sample_stb,
  input logic               fast_mode,
  input logic               sleep_act
);
  AST_FAST_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    period_wr |=> (fast_mode == ($past(period_val) <= SET_W'(FAST_LIMIT)))); // R4

  AST_NO_STB_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_act && $past(sleep_act)) |-> !sample_stb); // R8

  AST_SLEEP_START: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_wr && (sleep_val != '0) && !sleep_act) |=> sleep_act); // R7

  AST_SLEEP_ZERO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_act && !(sleep_wr && (sleep_val != '0))) |=> !sleep_act); // R9

  generate
    if (CLK_DIV > 1) begin : g_width
      AST_STB_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb); // R3
    end
  endgenerate
endmodule

bind sample_sleep_timer sample_sleep_timer_chk #(
  .CLK_DIV    (CLK_DIV),
  .SET_W      (SET_W),
  .SLEEP_W    (SLEEP_W),
  .FAST_LIMIT (FAST_LIMIT)
) u_chk (.*);

// File: tb/sample_sleep_timer_tb.sv
module sample_sleep_timer_tb;
  localparam int DIV = 2;
  localparam int H   = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       period_wr = 1'b0;
  logic [7:0] period_val = 8'h00;
  logic       sleep_wr = 1'b0;
  logic [7:0] sleep_val = 8'h00;
  logic       sample_stb, fast_mode, sleep_act;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  sample_sleep_timer #(.CLK_DIV(DIV), .HALF_SEC_TICKS(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .period_wr(period_wr), .period_val(period_val),
    .sleep_wr(sleep_wr), .sleep_val(sleep_val), .sample_stb(sample_stb),
    .fast_mode(fast_mode), .sleep_act(sleep_act)
  );

  function automatic int exp_ticks(input logic [7:0] s);
    return (s[7] ? 62 : 2) * int'(s[6:0]) + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      summary();
      $finish;
    end
  end

  task automatic wait_stb(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sample_stb && n < 20000);
  endtask

  task automatic wr_period(input logic [7:0] v);
    period_wr = 1'b1; period_val = v;
    @(negedge clk);
    period_wr = 1'b0;
  endtask

  task automatic wr_sleep(input logic [7:0] v);
    sleep_wr = 1'b1; sleep_val = v;
    @(negedge clk);
    sleep_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic measure_setting(input logic [7:0] v, input string req);
    int n;
    wr_period(v);
    wait_stb(n);
    wait_stb(n);
    chk(n == exp_ticks(v) * DIV, req, n, exp_ticks(v) * DIV);
  endtask

  initial begin
    int n, len, stbs, total;
    logic still;
    // R2: reset state
    do_reset();
    chk(sample_stb == 1'b0, "R2 stb", int'(sample_stb), 0);
    chk(sleep_act == 1'b0, "R2 sleep", int'(sleep_act), 0);
    chk(fast_mode == 1'b1, "R2 fast", int'(fast_mode), 1);
    wait_stb(n);
    wait_stb(n);
    chk(n == 3 * DIV, "R2 default interval", n, 3 * DIV);
    // R3: strobe one cycle wide
    @(negedge clk);
    chk(sample_stb == 1'b0, "R3 width", int'(sample_stb), 0);

    // R4: fast flag over every setting
    for (int v = 0; v < 256; v++) begin
      wr_period(8'(v));
      chk(fast_mode == (v <= 7), "R4 fast flag", int'(fast_mode), int'(v <= 7));
    end

    // R1 / R6: interval sweep
    for (int v = 0; v < 64; v++) measure_setting(8'(v), (v == 0) ? "R6 zero mult fine" : "R1 fine base");
    measure_setting(8'h7F, "R1 fine max");
    measure_setting(8'h80, "R6 zero mult coarse");
    measure_setting(8'h81, "R1 coarse 1");
    measure_setting(8'h83, "R1 coarse 3");
    measure_setting(8'hFF, "R1 coarse max");

    // R5: change mid-interval
    measure_setting(8'h0A, "R1 setup 0x0A");
    @(negedge clk); @(negedge clk);
    wr_period(8'h02);
    wait_stb(n);
    total = 3 + n;
    chk(total == 21 * DIV, "R5 old interval completes", total, 21 * DIV);
    wait_stb(n);
    chk(n == 5 * DIV, "R5 new interval", n, 5 * DIV);

    // R7 / R8 / R9: timed sleep
    wr_period(8'h03);
    wait_stb(n);
    wait_stb(n);
    @(negedge clk);
    wr_sleep(8'd3);
    chk(sleep_act == 1'b1, "R7 sleep starts", int'(sleep_act), 1);
    len = 1; stbs = 0;
    forever begin
      sleep_wr = (len == 5); sleep_val = 8'd200;
      @(negedge clk);
      if (sample_stb) stbs++;
      if (!sleep_act) break;
      len++;
    end
    sleep_wr = 1'b0;
    chk(len >= (3 * H - 1) * DIV + 1 && len <= 3 * H * DIV, "R7 R9 sleep length", len, 3 * H * DIV);
    chk(stbs == 0, "R8 no strobe asleep", stbs, 0);
    wait_stb(n);
    chk(n >= 6 * DIV + 1 && n <= 7 * DIV, "R8 first interval after wake", n, 7 * DIV);
    wait_stb(n);
    chk(n == 7 * DIV, "R8 interval after wake", n, 7 * DIV);

    // R9: zero sleep write ignored
    wr_sleep(8'd0);
    chk(sleep_act == 1'b0, "R9 zero sleep", int'(sleep_act), 0);
    wait_stb(n);
    wait_stb(n);
    chk(n == 7 * DIV, "R9 sampling continues", n, 7 * DIV);

    // R10: only reset ends a sleep
    wr_sleep(8'd255);
    still = 1'b1;
    for (int i = 0; i < 300; i++) begin
      sleep_wr = (i == 50); sleep_val = 8'd0;
      period_wr = (i == 80); period_val = 8'h00;
      @(negedge clk);
      if (!sleep_act || sample_stb) still = 1'b0;
    end
    sleep_wr = 1'b0; period_wr = 1'b0;
    chk(still == 1'b1, "R10 sleep persists", int'(still), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(sleep_act == 1'b0, "R10 reset ends sleep", int'(sleep_act), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(fast_mode == 1'b1, "R10 default after reset", int'(fast_mode), 1);
    wait_stb(n);
    wait_stb(n);
    chk(n == 3 * DIV, "R10 default interval after reset", n, 3 * DIV);

    summary();
    $finish;
  end
endmodule